// File: doc/BRIEF.md
# Power-Good Gated CPU Frequency Strap Latch

This block reads a four-bit frequency-select strap exactly once, at the moment an active-low power-good input is first seen low and stable. It then holds that code for the rest of the session. The power-good low marks the point at which the processor supply has settled, so the strap pins must already be at their final levels by then. The held code is decoded into a CPU clock frequency index. The clock generators downstream read that index to choose their operating point.

Every pin passes through a multi-flop synchroniser first. A low on power-good counts only after it has been seen on a set number of consecutive synchronised samples, so a short glitch cannot arm the capture. Once the code is captured, the lock ignores further activity on power-good and on the strap pins. The exception is test mode: while the synchronised test input is high, each qualified low on power-good captures the pins again. A synchronous reset clears the lock so that a fresh capture can take place.

Top module: `fsel_strap_latch`

## Requirements
- R1: From reset until the first capture, `fsel_valid` is 0, `fsel_code` is 4'b0000 and `cpu_freq_idx` equals the default 4'b0111 (class 7, which no strap code produces, and overclock flag 0).
- R2: With the default parameters, if `pwrgd_n` falls and stays low, `fsel_valid` is still 0 after the 4th rising clock edge after the fall and is 1 after the 5th. `fsel_code` then holds the strap value that was present on the pins.
- R3: A low pulse on `pwrgd_n` that lasts one clock period never causes a capture. A low that lasts two clock periods does cause one.
- R4: Once `fsel_valid` is 1 and test mode is off, the held code does not change, whatever `pwrgd_n` and `fsel_pins` do.
- R5: While `test_en` is 1, each qualified low on `pwrgd_n` captures `fsel_pins` again, so the held code follows the pins.
- R6: `cpu_freq_idx[2:0]` is a rate class taken from `fsel_code[2:0]`. Code 101 gives class 0 (100 MHz), 001 gives class 1 (133), 011 gives class 2 (166), 010 gives class 3 (200), 000 gives class 4 (266), 100 gives class 5 (333), 110 gives class 6 (400), and 111 also gives class 3 (200).
- R7: `cpu_freq_idx[3]` is the overclock flag and equals `fsel_code[3]`, which selects the +0.9 MHz variant of the same class. Code 0111 therefore gives 4'b0011 and code 1111 gives 4'b1011.
- R8: Asserting `rst` clears `fsel_valid`, the held code and the lock. After `rst` is released, a new qualified low captures whatever strap value is on the pins at that time.
- R9: Once `fsel_valid` has risen, it stays 1 until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| fsel_pins | input | 4 | Asynchronous frequency-select strap pins |
| pwrgd_n | input | 1 | Asynchronous power-good, active low |
| test_en | input | 1 | Asynchronous test-mode input that bypasses the one-shot lock |
| fsel_code | output | 4 | Captured strap code |
| fsel_valid | output | 1 | High once a code has been captured |
| cpu_freq_idx | output | 4 | Decoded index: bit 3 is the overclock flag, bits 2:0 are the rate class |

## Verification
The assertions assume that the strap pins and the test input do not change in the window between a power-good fall and its capture. The check on a stable held code also relies on test mode being off in the synchronised domain. The stimulus therefore sets the strap pins and `test_en` several cycles before it drops `pwrgd_n`, and it changes them only after the expected capture edge. It drives every pin at the falling clock edge, so the synchroniser always sees clean levels.

// File: rtl/fsel_pkg.sv
package fsel_pkg;

   localparam int unsigned SEL_W = 4;
   localparam int unsigned CLS_W = 3;

   typedef struct packed {
      logic             ovr;
      logic [CLS_W-1:0] cls;
   } cpu_idx_t;

   localparam cpu_idx_t IDX_NONE = '{ovr: 1'b0, cls: 3'd7};

   function automatic logic [CLS_W-1:0] strap_class(input logic [CLS_W-1:0] low_bits);
      logic [CLS_W-1:0] c;
      case (low_bits)
         3'b101:  c = 3'd0;
         3'b001:  c = 3'd1;
         3'b011:  c = 3'd2;
         3'b010:  c = 3'd3;
         3'b000:  c = 3'd4;
         3'b100:  c = 3'd5;
         3'b110:  c = 3'd6;
         default: c = 3'd3;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/fsel_sync.sv
module fsel_sync #(
   parameter int unsigned     W       = 1,
   parameter int unsigned     STAGES  = 2,
   parameter logic [W-1:0]    RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d_async,
   output logic [W-1:0] q_sync
);

   if (STAGES < 2) begin : g_bad_stages
      $error("fsel_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("fsel_sync: W must be at least 1");
   end

   logic [W-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
         if (rst) begin
            stage_q[s] <= RST_VAL;
         end else begin
            if (s == 0) stage_q[s] <= d_async;
            else        stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
         end
      end
   end

   assign q_sync = stage_q[STAGES-1];

endmodule

// File: rtl/fsel_low_qual.sv
module fsel_low_qual #(
   parameter int unsigned CONFIRM = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic level_n,
   output logic qual_low
);

   if (CONFIRM < 1) begin : g_bad_confirm
      $error("fsel_low_qual: CONFIRM must be at least 1");
   end

   logic is_low;
   assign is_low = ~level_n;

   if (CONFIRM == 1) begin : g_direct
      always_ff @(posedge clk) begin
         if (rst) qual_low <= 1'b0;
         else     qual_low <= is_low;
      end
   end else begin : g_count
      localparam int unsigned CW = $clog2(CONFIRM + 1);
      localparam logic [CW-1:0] LAST = CW'(CONFIRM - 1);

      logic [CW-1:0] run_q;

      always_ff @(posedge clk) begin
         if (rst) begin
            run_q    <= '0;
            qual_low <= 1'b0;
         end else if (!is_low) begin
            run_q    <= '0;
            qual_low <= 1'b0;
         end else begin
            if (run_q != LAST) run_q <= run_q + 1'b1;
            qual_low <= (run_q == LAST);
         end
      end

      // R3: a qualified low needs a full run of consecutive low samples
      assert_qual_after_run_R3: assert property (@(posedge clk) disable iff (rst)
         $rose(qual_low) |-> ($past(run_q) == LAST))
         else $error("qualified low without a complete run");

      assert_run_bounded_R3: assert property (@(posedge clk) disable iff (rst)
         run_q <= LAST)
         else $error("run counter exceeded its limit");
   end

   // R3: the qualified flag only follows a low sample
   assert_qual_needs_low_R3: assert property (@(posedge clk) disable iff (rst)
      qual_low |-> $past(is_low))
      else $error("qualified low after a high sample");

endmodule

// File: rtl/fsel_capture.sv
module fsel_capture #(
   parameter int unsigned W = 4
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         qual_low,
   input  logic         test_mode,
   input  logic [W-1:0] sel_sync,
   output logic [W-1:0] code_q,
   output logic         valid_q
);

   logic take;
   assign take = qual_low && (!valid_q || test_mode);

   always_ff @(posedge clk) begin
      if (rst) begin
         code_q  <= '0;
         valid_q <= 1'b0;
      end else if (take) begin
         code_q  <= sel_sync;
         valid_q <= 1'b1;
      end
   end

   // R2: a capture is always preceded by a qualified low
   assert_capture_qualified_R2: assert property (@(posedge clk) disable iff (rst)
      $rose(valid_q) |-> $past(qual_low))
      else $error("capture without qualified low");

   // R4: once locked outside test mode the code is frozen
   assert_locked_stable_R4: assert property (@(posedge clk) disable iff (rst)
      (valid_q && !test_mode) |=> $stable(code_q))
      else $error("held code changed while locked");

   // R9: valid never drops without reset
   assert_valid_sticky_R9: assert property (@(posedge clk) disable iff (rst)
      valid_q |=> valid_q)
      else $error("valid dropped without reset");

   // R1: before capture the held code stays at its reset value
   assert_code_clear_R1: assert property (@(posedge clk) disable iff (rst)
      !valid_q |-> (code_q == '0))
      else $error("code non-zero before capture");

endmodule

// File: rtl/fsel_decode.sv
module fsel_decode
   import fsel_pkg::*;
(
   input  logic [SEL_W-1:0] code,
   input  logic             valid,
   output cpu_idx_t         idx
);

   always_comb begin
      if (valid) begin
         idx.ovr = code[SEL_W-1];
         idx.cls = strap_class(code[CLS_W-1:0]);
      end else begin
         idx = IDX_NONE;
      end
   end

endmodule

// File: rtl/fsel_strap_latch.sv
module fsel_strap_latch
   import fsel_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned CONFIRM     = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [SEL_W-1:0] fsel_pins,
   input  logic             pwrgd_n,
   input  logic             test_en,
   output logic [SEL_W-1:0] fsel_code,
   output logic             fsel_valid,
   output logic [SEL_W-1:0] cpu_freq_idx
);

   localparam int unsigned BUS_W = SEL_W + 2;
   localparam logic [BUS_W-1:0] BUS_RST = {1'b0, 1'b1, {SEL_W{1'b0}}};

   if (SEL_W != 4) begin : g_bad_sel
      $error("fsel_strap_latch: decoder expects a four-bit strap");
   end

   logic [BUS_W-1:0] bus_sync;
   logic             qual_low;
   cpu_idx_t         idx;

   fsel_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL(BUS_RST)) u_sync (
      .clk     (clk),
      .rst     (rst),
      .d_async ({test_en, pwrgd_n, fsel_pins}),
      .q_sync  (bus_sync)
   );

   fsel_low_qual #(.CONFIRM(CONFIRM)) u_qual (
      .clk      (clk),
      .rst      (rst),
      .level_n  (bus_sync[SEL_W]),
      .qual_low (qual_low)
   );

   fsel_capture #(.W(SEL_W)) u_cap (
      .clk       (clk),
      .rst       (rst),
      .qual_low  (qual_low),
      .test_mode (bus_sync[SEL_W+1]),
      .sel_sync  (bus_sync[SEL_W-1:0]),
      .code_q    (fsel_code),
      .valid_q   (fsel_valid)
   );

   fsel_decode u_dec (
      .code  (fsel_code),
      .valid (fsel_valid),
      .idx   (idx)
   );

   assign cpu_freq_idx = idx;

   // R1: default index until a code is held
   assert_default_idx_R1: assert property (@(posedge clk) disable iff (rst)
      !fsel_valid |-> (cpu_freq_idx == IDX_NONE))
      else $error("index not at default before capture");

   // R7: overclock flag mirrors the top strap bit once valid
   assert_ovr_flag_R7: assert property (@(posedge clk) disable iff (rst)
      fsel_valid |-> (cpu_freq_idx[SEL_W-1] == fsel_code[SEL_W-1]))
      else $error("overclock flag mismatch");

   // R6: a held code never decodes to the unused class
   assert_class_used_R6: assert property (@(posedge clk) disable iff (rst)
      fsel_valid |-> (cpu_freq_idx[CLS_W-1:0] != 3'd7))
      else $error("decoded unused class");

endmodule

// File: tb/test_fsel_strap_latch.sv
module test_fsel_strap_latch;

   logic       clk = 1'b0;
   logic       rst;
   logic [3:0] fsel_pins;
   logic       pwrgd_n;
   logic       test_en;
   logic [3:0] fsel_code;
   logic       fsel_valid;
   logic [3:0] cpu_freq_idx;

   int n_checks = 0;
   int n_bad    = 0;

   always #2.5 clk = ~clk;

   fsel_strap_latch i_fsel_strap_latch (
      .clk          (clk),
      .rst          (rst),
      .fsel_pins    (fsel_pins),
      .pwrgd_n      (pwrgd_n),
      .test_en      (test_en),
      .fsel_code    (fsel_code),
      .fsel_valid   (fsel_valid),
      .cpu_freq_idx (cpu_freq_idx)
   );

   function automatic logic [3:0] exp_idx(input logic [3:0] c);
      logic [2:0] k;
      case (c[2:0])
         3'b101: k = 3'd0;
         3'b001: k = 3'd1;
         3'b011: k = 3'd2;
         3'b010: k = 3'd3;
         3'b000: k = 3'd4;
         3'b100: k = 3'd5;
         3'b110: k = 3'd6;
         default: k = 3'd3;
      endcase
      return {c[3], k};
   endfunction

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic do_reset(input logic [3:0] pins);
      @(negedge clk);
      rst = 1'b1; fsel_pins = pins; pwrgd_n = 1'b1; test_en = 1'b0;
      wait_n(3);
      rst = 1'b0;
      wait_n(3);
   endtask

   task automatic t_reset_state();
      do_reset(4'b0101);
      check("R1 valid", {7'd0, fsel_valid}, 8'd0);
      check("R1 code", {4'd0, fsel_code}, 8'd0);
      check("R1 idx", {4'd0, cpu_freq_idx}, 8'h07);
   endtask

   task automatic t_capture_timing();
      do_reset(4'b0011);
      pwrgd_n = 1'b0;
      wait_n(4);
      check("R2 not yet valid", {7'd0, fsel_valid}, 8'd0);
      check("R1 idx before capture", {4'd0, cpu_freq_idx}, 8'h07);
      wait_n(1);
      check("R2 valid at 5th edge", {7'd0, fsel_valid}, 8'd1);
      check("R2 code", {4'd0, fsel_code}, 8'h03);
      check("R6 idx 166", {4'd0, cpu_freq_idx}, 8'h02);
   endtask

   task automatic t_glitch();
      do_reset(4'b0110);
      pwrgd_n = 1'b0;
      wait_n(1);
      pwrgd_n = 1'b1;
      wait_n(10);
      check("R3 one-cycle low ignored", {7'd0, fsel_valid}, 8'd0);
      pwrgd_n = 1'b0;
      wait_n(2);
      pwrgd_n = 1'b1;
      wait_n(10);
      check("R3 two-cycle low captured", {7'd0, fsel_valid}, 8'd1);
      check("R3 code", {4'd0, fsel_code}, 8'h06);
   endtask

   task automatic t_lock();
      do_reset(4'b0001);
      pwrgd_n = 1'b0;
      wait_n(8);
      fsel_pins = 4'b1110;
      pwrgd_n = 1'b1;
      wait_n(5);
      pwrgd_n = 1'b0;
      wait_n(10);
      check("R4 code frozen", {4'd0, fsel_code}, 8'h01);
      check("R4 idx frozen", {4'd0, cpu_freq_idx}, 8'h01);
      check("R9 valid held", {7'd0, fsel_valid}, 8'd1);
   endtask

   task automatic t_test_mode();
      do_reset(4'b0100);
      pwrgd_n = 1'b0;
      wait_n(8);
      check("R5 first capture", {4'd0, fsel_code}, 8'h04);
      test_en = 1'b1;
      wait_n(4);
      fsel_pins = 4'b1010;
      wait_n(6);
      check("R5 recapture", {4'd0, fsel_code}, 8'h0A);
      check("R7 idx 200.9", {4'd0, cpu_freq_idx}, 8'h0B);
      test_en = 1'b0;
      wait_n(4);
      fsel_pins = 4'b0000;
      wait_n(8);
      check("R4 frozen after test mode", {4'd0, fsel_code}, 8'h0A);
   endtask

   task automatic t_decode_all();
      for (int c = 0; c < 16; c++) begin
         do_reset(4'(c));
         pwrgd_n = 1'b0;
         wait_n(8);
         check((c < 8) ? "R6 decode" : "R7 decode", {4'd0, cpu_freq_idx}, {4'd0, exp_idx(4'(c))});
      end
   endtask

   task automatic t_reset_relock();
      do_reset(4'b1101);
      pwrgd_n = 1'b0;
      wait_n(8);
      check("R8 first capture", {4'd0, fsel_code}, 8'h0D);
      rst = 1'b1;
      wait_n(2);
      check("R8 valid cleared", {7'd0, fsel_valid}, 8'd0);
      check("R8 code cleared", {4'd0, fsel_code}, 8'd0);
      fsel_pins = 4'b1000;
      rst = 1'b0;
      wait_n(8);
      check("R8 recaptured", {4'd0, fsel_code}, 8'h08);
      check("R8 idx 266.9", {4'd0, cpu_freq_idx}, 8'h0C);
   endtask

   initial begin
      rst = 1'b1; fsel_pins = 4'd0; pwrgd_n = 1'b1; test_en = 1'b0;
      t_reset_state();
      t_capture_timing();
      t_glitch();
      t_lock();
      t_test_mode();
      t_decode_all();
      t_reset_relock();
      $display("test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_checks++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
   end

endmodule